// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is a two-wire serial bus slave placed in front of a byte-wide memory. A 17-bit byte address is spread across three bytes: its top bit travels in the device select byte, and the other sixteen bits follow in two address bytes. The block samples the clock and data lines with the system clock and detects Start and Stop conditions. It answers a device select byte only when that byte carries the fixed type code 1010 and the two strapped chip-enable values. It then performs byte writes, sequential writes, current-address reads, random reads and sequential reads. A write-lock input refuses data bytes.

The data line is open-drain. The block does not drive a level onto the line. Instead, `sda_pull_o` asks the pad to pull the line low, and the value seen on the line comes back on `sda_i`. Both `scl_i` and `sda_i` pass through a synchronizer. Each SCL high phase and each SCL low phase must therefore last several system clocks.

The memory is a RAM with a registered read port, so an FPGA can map it to block RAM. It holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of the 17-bit address. Setting MEM_AW to 17 gives the full 128K array. When a write ends with a Stop and at least one byte was stored, the block models the cell programming time as a busy window of BUSY_CYC system clocks.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the block does not pull SDA low and is idle. A Start condition (SDA falls while SCL is high) abandons any byte in progress, and the block then waits for a new device select byte. A Stop condition (SDA rises while SCL is high) returns the block to idle.
- R2: The device select byte is, from MSB to LSB: type code 1010, E2, E1, A16, R/W. The block acknowledges it only when bits 7:4 are 1010 and bits 3:2 equal `chip_sel_i[1:0]`. Otherwise SDA stays high in the 9th clock and the block ignores the bus until the next Start.
- R3: The block acknowledges a byte from the master by pulling SDA low during the 9th SCL period. It changes `sda_pull_o` only while SCL is low, and it releases SDA after the acknowledge.
- R4: In a write, A16 is bit 1 of the select byte. The next two bytes are address bits 15:8 and then bits 7:0. The address counter loads when the second address byte is accepted.
- R5: Each data byte that is accepted is stored at the counter. The counter then increments its low 8 bits only, so sequential writes wrap inside a 256-byte page.
- R6: While `wr_lock_i` is high, the select byte and address bytes are still acknowledged. Data bytes are not acknowledged. Memory is unchanged and the counter stays at the loaded address.
- R7: A select byte with R/W=1 starts a read at the current counter; the A16 bit of a read select is ignored. Each byte is sent MSB first. The counter increments over all 17 bits, so 1FFFF is followed by 00000.
- R8: A random read is a write select byte and two address bytes, then a repeated Start and a read select byte. It returns the byte at the loaded address.
- R9: During a read, a master acknowledge (SDA low in the 9th period) makes the block send the next byte. A master no-acknowledge ends the read, and SDA is left released.
- R10: After a Stop that ends a write in which a byte was stored, the block refuses to acknowledge any device select byte for BUSY_CYC system clocks. After that it acknowledges again.
- R11: Memory locations are selected by the low MEM_AW address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Level seen on the serial data line |
| sda_pull_o | output | 1 | When high, the pad pulls the data line low |
| chip_sel_i | input | 2 | Strapped chip-enable values: bit 1 is E2, bit 0 is E1 |
| wr_lock_i | input | 1 | When high, data bytes of writes are refused |

## Verification
Select bytes are tried with a wrong type code, with wrong chip-enable bits and with a correct byte. This separates the code match from the strap match. Directed writes are placed at the end of a page, at address 1FFFF and at 00000. Reading these back separates page-local wrap on writes from full-array wrap on reads, and shows how addresses alias into the smaller memory. A write with the lock raised is followed by a current-address read, which shows both that memory is unchanged and that the counter did not move. A select probe sent right after a write's Stop, and another sent after the busy window, bound that window. Random addresses and burst lengths then compare the data read back against a bench model of the memory.

// File: rtl/seep_pkg.sv
package seep_pkg;
  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int ADDR_W = 17;
  localparam int PAGE_W = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} seep_state_e;
  typedef enum logic [1:0] {SG_DEV, SG_AHI, SG_ALO, SG_DAT} seep_stage_e;
endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/seep_ram.sv
module seep_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seep_busy_timer.sv
module seep_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)               remain <= '0;
    else if (kick)         remain <= CW'(CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import seep_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int BUSY_CYC    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] chip_sel_i,
  input  logic       wr_lock_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  seep_state_e state;
  seep_stage_e stage;
  logic [3:0]        cnt;
  logic [7:0]        shreg, txsh, hi_tmp, rdata, wd_q;
  logic [ADDR_W-1:0] addr;
  logic              a16_tmp, ack_q, tx_next, mack_q, pend_busy;
  logic              we_q, kick, busy, byte_ok;
  logic [MEM_AW-1:0] wa_q;

  seep_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  seep_ram #(.AW(MEM_AW), .DW(8)) i_ram (
    .clk(clk), .we(we_q), .waddr(wa_q), .wdata(wd_q),
    .raddr(addr[MEM_AW-1:0]), .rdata(rdata)
  );

  seep_busy_timer #(.CYCLES(BUSY_CYC)) i_busy (
    .clk(clk), .rst(rst), .kick(kick), .busy(busy)
  );

  // Decide whether the byte just shifted in earns an acknowledge.
  always_comb begin
    unique case (stage)
      SG_DEV:  byte_ok = (shreg[7:4] == TYPE_CODE) && (shreg[3:2] == chip_sel_i) && !busy;
      SG_DAT:  byte_ok = !wr_lock_i;
      default: byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      stage      <= SG_DEV;
      cnt        <= '0;
      shreg      <= '0;
      txsh       <= '0;
      hi_tmp     <= '0;
      addr       <= '0;
      a16_tmp    <= 1'b0;
      ack_q      <= 1'b0;
      tx_next    <= 1'b0;
      mack_q     <= 1'b0;
      pend_busy  <= 1'b0;
      we_q       <= 1'b0;
      wa_q       <= '0;
      wd_q       <= '0;
      kick       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else begin
      we_q <= 1'b0;
      kick <= 1'b0;
      if (start_ev) begin
        state      <= ST_RX;
        stage      <= SG_DEV;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        if (pend_busy) begin
          kick      <= 1'b1;
          pend_busy <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              state      <= ST_ACK;
              ack_q      <= byte_ok;
              sda_pull_o <= byte_ok;
              tx_next    <= 1'b0;
              unique case (stage)
                SG_DEV: if (byte_ok) begin
                  tx_next <= shreg[0];
                  if (!shreg[0]) a16_tmp <= shreg[1];
                  stage <= SG_AHI;
                end
                SG_AHI: begin
                  hi_tmp <= shreg;
                  stage  <= SG_ALO;
                end
                SG_ALO: begin
                  addr  <= {a16_tmp, hi_tmp, shreg};
                  stage <= SG_DAT;
                end
                SG_DAT: if (byte_ok) begin
                  we_q      <= 1'b1;
                  wa_q      <= addr[MEM_AW-1:0];
                  wd_q      <= shreg;
                  addr      <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                  pend_busy <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_q) begin
              state      <= ST_IDLE;
              sda_pull_o <= 1'b0;
            end else if (tx_next) begin
              txsh       <= rdata;
              sda_pull_o <= ~rdata[7];
              addr       <= addr + 1'b1;
              cnt        <= '0;
              state      <= ST_TX;
            end else begin
              state      <= ST_RX;
              cnt        <= '0;
              sda_pull_o <= 1'b0;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_pull_o <= 1'b0;
              state      <= ST_MACK;
            end else begin
              txsh       <= {txsh[6:0], 1'b0};
              sda_pull_o <= ~txsh[6];
              cnt        <= cnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                txsh       <= rdata;
                sda_pull_o <= ~rdata[7];
                addr       <= addr + 1'b1;
                cnt        <= '0;
                state      <= ST_TX;
              end else begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/seep_chk.sv
module seep_chk
  import seep_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              sda_pull_o,
  input seep_state_e       state,
  input logic [3:0]        cnt,
  input logic              busy,
  input logic              we_q,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_lock_i
);
  // R1
  start_resets_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_RX && cnt == 4'd0));

  // R1
  stop_idles_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && !start_ev) |=> (state == ST_IDLE && !sda_pull_o));

  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull_o));

  // R9
  pull_owner_chk: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> (state == ST_ACK || state == ST_TX));

  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_q) |-> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]) &&
                     addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + 8'd1));

  // R6
  lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !wr_lock_i);

  // R10
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull_o);
endmodule

bind serial_eeprom_slave seep_chk i_seep_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_pull_o(sda_pull_o), .state(state), .cnt(cnt), .busy(busy),
  .we_q(we_q), .addr(addr), .wr_lock_i(wr_lock_i)
);

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int MEM_AW   = 11;
  localparam int BUSY_CYC = 1000;
  localparam int Q        = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic lock = 1'b0;
  logic [1:0] pins = 2'b10;
  logic sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int fails = 0;
  int conflicts = 0;
  logic [7:0] model [0:(1<<MEM_AW)-1];

  always #5 clk = ~clk;

  serial_eeprom_slave #(.MEM_AW(MEM_AW), .BUSY_CYC(BUSY_CYC), .SYNC_STAGES(2)) i_serial_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .chip_sel_i(pins), .wr_lock_i(lock)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q);
    if (b && !sda_bus) conflicts++;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!mack);
  endtask

  function automatic logic [7:0] sel(input bit rd, input logic [16:0] a);
    return {4'b1010, pins, a[16], rd};
  endfunction

  function automatic logic [16:0] pinc(input logic [16:0] a);
    return {a[16:8], a[7:0] + 8'd1};
  endfunction

  // Writes n bytes from address a; one check covers every acknowledge seen.
  task automatic write_bytes(input logic [16:0] a, input int n, input bit wait_busy, input string req);
    bit ok, ak;
    logic [7:0] v;
    logic [16:0] p;
    ok = 1'b1;
    p = a;
    bus_start;
    put_byte(sel(1'b0, a), ak); ok &= ak;
    put_byte(a[15:8], ak);      ok &= ak;
    put_byte(a[7:0], ak);       ok &= ak;
    for (int i = 0; i < n; i++) begin
      v = 8'($urandom);
      put_byte(v, ak);
      if (lock) begin
        ok &= !ak;
        break;
      end
      ok &= ak;
      model[p[MEM_AW-1:0]] = v;
      p = pinc(p);
    end
    bus_stop;
    check_eq(req, {31'd0, ok}, 32'd1);
    if (wait_busy && !lock && n > 0) wq(BUSY_CYC + 40);
  endtask

  // Random read (rnd=1) or current-address read (rnd=0) of n bytes expected from a.
  task automatic read_from(input bit rnd, input logic [16:0] a, input int n, input string req);
    bit ak;
    logic [7:0] v;
    logic [16:0] p;
    p = a;
    bus_start;
    if (rnd) begin
      put_byte(sel(1'b0, a), ak); check_eq(req, {31'd0, ak}, 32'd1);
      put_byte(a[15:8], ak);
      put_byte(a[7:0], ak);
      bus_start;
    end
    put_byte(sel(1'b1, a), ak);
    check_eq(req, {31'd0, ak}, 32'd1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, v);
      check_eq(req, {24'd0, v}, {24'd0, model[p[MEM_AW-1:0]]});
      p = p + 17'd1;
    end
    bus_stop;
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run;
  end

  initial begin
    bit ak;
    logic [16:0] a;
    int n;
    void'($urandom(32'd2024));
    wq(10);
    rst = 1'b0;
    wq(10);
    check_eq("R1 reset released", {31'd0, sda_pull}, 32'd0);

    // R2: wrong type code, wrong chip enables, then a matching select
    bus_start; put_byte(8'b1011_1000, ak); bus_stop;
    check_eq("R2 bad type code", {31'd0, ak}, 32'd0);
    bus_start; put_byte(8'b1010_0100, ak); bus_stop;
    check_eq("R2 bad chip enable", {31'd0, ak}, 32'd0);
    bus_start; put_byte(sel(1'b0, 17'd0), ak); bus_stop;
    check_eq("R2 R3 matching select acked", {31'd0, ak}, 32'd1);

    // R1: Start in the middle of a byte abandons it
    bus_start;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start; put_byte(sel(1'b0, 17'd0), ak); bus_stop;
    check_eq("R1 restart mid byte", {31'd0, ak}, 32'd1);

    // R4 R8 R11: write with A16 set, random read back
    write_bytes(17'h12345, 1, 1'b1, "R4 write at 12345");
    read_from(1'b1, 17'h12345, 1, "R8 random read");

    // R10: busy window after a write
    write_bytes(17'h00010, 1, 1'b0, "R5 byte write");
    bus_start; put_byte(sel(1'b0, 17'd0), ak); bus_stop;
    check_eq("R10 select refused while busy", {31'd0, ak}, 32'd0);
    wq(BUSY_CYC);
    bus_start; put_byte(sel(1'b0, 17'd0), ak); bus_stop;
    check_eq("R10 select acked after busy", {31'd0, ak}, 32'd1);

    // R5: page wrap of a sequential write, R9 sequential read
    write_bytes(17'h002FE, 4, 1'b1, "R5 page wrap write");
    read_from(1'b1, 17'h002FE, 2, "R5 R9 page end");
    read_from(1'b1, 17'h00200, 2, "R5 R9 page start");
    check_eq("R9 released after no-ack", {31'd0, sda_pull}, 32'd0);

    // R6: locked write leaves memory and counter alone
    lock = 1'b1;
    write_bytes(17'h00200, 1, 1'b1, "R6 locked data refused");
    lock = 1'b0;
    read_from(1'b0, 17'h00200, 1, "R6 memory and counter unchanged");

    // R7 R11: full-array wrap on reads
    write_bytes(17'h1FFFF, 1, 1'b1, "R4 write at 1FFFF");
    write_bytes(17'h00000, 1, 1'b1, "R4 write at 00000");
    read_from(1'b1, 17'h1FFFF, 1, "R11 read at 1FFFF");
    read_from(1'b0, 17'h00000, 1, "R7 current read after wrap");

    // Random bursts inside one page
    for (int k = 0; k < 12; k++) begin
      a = 17'($urandom);
      a[7:0] = 8'($urandom % 252);
      n = 1 + int'($urandom % 4);
      if ($urandom % 5 == 0) begin
        lock = 1'b1;
        write_bytes(a, n, 1'b1, "R6 random locked write");
        lock = 1'b0;
      end else begin
        write_bytes(a, n, 1'b1, "R5 random burst");
        read_from(1'b1, a, n, "R8 R9 random readback");
      end
    end

    check_eq("R3 no bus conflict", conflicts, 32'd0);
    finish_run;
  end
endmodule